// File: doc/BRIEF.md
# Pause and Backpressure Flow Controller

This block drives transmit-side flow control for an Ethernet MAC. It has two modes. In full-duplex mode it asks the frame transmitter for a PAUSE control frame and supplies the 16-bit pause time that goes into that frame. It then re-issues the request at a programmed interval for as long as flow control stays enabled. When flow control is withdrawn, it asks for one final frame with a pause time of zero. In half-duplex mode it asserts a backpressure line for a programmed number of clock cycles.

One 16-bit up-counter serves both modes. In full duplex it paces the re-issue of PAUSE requests. In half duplex it times the backpressure window. Its live value is shown on a 32-bit status word. A single 32-bit configuration word supplies the re-issue interval in bits 15:0 and the pause time, or the backpressure length, in bits 31:16. The mode is sampled only while the block is idle.

Top module: `flow_pacer`

## Requirements
- R1: After a synchronous reset, `pause_req`, `backpressure`, `pause_time` and `count_status` are all zero.
- R2: In full duplex, one clock edge after `fc_enable` is seen high while idle, `pause_req` goes high and `pause_time` equals `cfg_word[31:16]`.
- R3: `pause_req` stays high until `pause_sent` is seen high at a clock edge. While a request is pending, the counter shown in `count_status[15:0]` does not change.
- R4: The edge that accepts `pause_sent` clears the counter to 0. After that the counter rises by one per cycle. When it equals a non-zero interval `cfg_word[15:0]`, `pause_req` rises at the next edge, so the gap from the acknowledge edge is interval+1 cycles. `count_status[31:16]` always reads zero.
- R5: In full duplex with an interval of zero, the request is made once and never re-issued, and the counter stays at 0.
- R6: When `fc_enable` is low at an edge in full duplex while the block is active, `pause_req` is high at the next edge with `pause_time` equal to 0 and the counter equal to 0. After that request is acknowledged, the block returns to idle with `pause_req` low.
- R7: In half duplex with a non-zero `cfg_word[31:16]` = N, `backpressure` is high for exactly N cycles. The counter then holds at N while `fc_enable` stays high. `pause_req` never rises in half duplex.
- R8: In half duplex with `cfg_word[31:16]` equal to zero, `backpressure` never rises.
- R9: In half duplex, if `fc_enable` is low at an edge, `backpressure` is low and the counter is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | 1 = full duplex (PAUSE frames), 0 = half duplex (backpressure); sampled when idle |
| fc_enable | input | 1 | Flow control asserted |
| cfg_word | input | 32 | [15:0] re-issue interval, [31:16] pause time / backpressure cycles |
| pause_sent | input | 1 | Transmitter acknowledge that the requested PAUSE frame was sent |
| pause_req | output | 1 | Request for a PAUSE frame, held until acknowledged |
| pause_time | output | 16 | Pause-time field for the requested frame |
| backpressure | output | 1 | Half-duplex backpressure |
| count_status | output | 32 | Live counter in [15:0], zero in [31:16] |

## Verification
A controller state that does not match its counter shows on the ports within one cycle. A request that drops before its acknowledge, or a counter that keeps running while a request is pending, is seen at the next sampling point on `pause_req` or `count_status`. A wrong re-issue or backpressure length changes the measured number of cycles between edges by at least one. A counter that misses its clear shows as a non-zero status value on the cycle right after an acknowledge or a release.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam int CNT_W = 16;
    localparam int CFG_W = 2 * CNT_W;

    typedef enum logic [2:0] {
        FC_IDLE,
        FC_REQ,
        FC_WAIT,
        FC_ZREQ,
        FC_BP,
        FC_BPDONE
    } fc_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] hold_time;
        logic [CNT_W-1:0] gap;
    } fc_cfg_t;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_cmd_t;

    function automatic fc_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        return fc_cfg_t'(w);
    endfunction

    function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] lim);
        return ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, lim};
    endfunction
endpackage

// File: rtl/fcc_count.sv
module fcc_count
    import fcc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_cmd_t     cmd,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || cmd.clr) begin
            count <= '0;
        end else if (cmd.inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             full_duplex,
    input  logic             fc_enable,
    input  fc_cfg_t          cfg,
    input  logic             pause_sent,
    input  logic [CNT_W-1:0] count,
    output cnt_cmd_t         cmd,
    output logic             pause_req,
    output logic [CNT_W-1:0] pause_time,
    output logic             backpressure
);
    fc_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= FC_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        cmd      = '{clr: 1'b0, inc: 1'b0};
        unique case (state)
            FC_IDLE: begin
                cmd.clr = 1'b1;
                if (fc_enable) begin
                    if (full_duplex)              state_nx = FC_REQ;
                    else if (cfg.hold_time == '0) state_nx = FC_BPDONE;
                    else                          state_nx = FC_BP;
                end
            end
            FC_REQ: begin
                if (!fc_enable) begin
                    cmd.clr  = 1'b1;
                    state_nx = FC_ZREQ;
                end else if (pause_sent) begin
                    cmd.clr  = 1'b1;
                    state_nx = FC_WAIT;
                end
            end
            FC_WAIT: begin
                if (!fc_enable) begin
                    cmd.clr  = 1'b1;
                    state_nx = FC_ZREQ;
                end else if (cfg.gap != '0) begin
                    if (count == cfg.gap) state_nx = FC_REQ;
                    else                  cmd.inc  = 1'b1;
                end
            end
            FC_ZREQ: begin
                cmd.clr = 1'b1;
                if (pause_sent) state_nx = FC_IDLE;
            end
            FC_BP: begin
                if (!fc_enable) begin
                    cmd.clr  = 1'b1;
                    state_nx = FC_IDLE;
                end else begin
                    cmd.inc = 1'b1;
                    if (reached(count, cfg.hold_time)) state_nx = FC_BPDONE;
                end
            end
            FC_BPDONE: begin
                if (!fc_enable) begin
                    cmd.clr  = 1'b1;
                    state_nx = FC_IDLE;
                end
            end
            default: state_nx = FC_IDLE;
        endcase
    end

    assign pause_req    = (state == FC_REQ) || (state == FC_ZREQ);
    assign pause_time   = (state == FC_REQ) ? cfg.hold_time : '0;
    assign backpressure = (state == FC_BP);

    // R3: a pending request survives until acknowledged
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !pause_sent && fc_enable && state == FC_REQ) |=> pause_req);

    // R3: the counter is frozen while a request is pending
    a_r3_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (state == FC_REQ && !pause_sent && fc_enable) |=> $stable(count));

    // R4: the acknowledge edge restarts the counter at zero
    a_r4_clear_on_ack: assert property (@(posedge clk) disable iff (rst)
        (pause_req && pause_sent) |=> (count == '0));

    // R6: withdrawal in full duplex yields a zero-time request
    a_r6_zero_final: assert property (@(posedge clk) disable iff (rst)
        (!fc_enable && state == FC_WAIT) |=> (pause_req && pause_time == '0));

    // R7: the backpressure window never outruns the programmed length
    a_r7_bp_bound: assert property (@(posedge clk) disable iff (rst)
        backpressure |-> (count < cfg.hold_time));

    // R9: a low enable always releases backpressure at the next edge
    a_r9_bp_release: assert property (@(posedge clk) disable iff (rst)
        !fc_enable |=> !backpressure);
endmodule

// File: rtl/flow_pacer.sv
module flow_pacer
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             full_duplex,
    input  logic             fc_enable,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             pause_sent,
    output logic             pause_req,
    output logic [CNT_W-1:0] pause_time,
    output logic             backpressure,
    output logic [CFG_W-1:0] count_status
);
    cnt_cmd_t         cmd;
    logic [CNT_W-1:0] count;
    fc_cfg_t          cfg;

    assign cfg = unpack_cfg(cfg_word);

    fcc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .full_duplex  (full_duplex),
        .fc_enable    (fc_enable),
        .cfg          (cfg),
        .pause_sent   (pause_sent),
        .count        (count),
        .cmd          (cmd),
        .pause_req    (pause_req),
        .pause_time   (pause_time),
        .backpressure (backpressure)
    );

    fcc_count #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .count (count)
    );

    assign count_status = {{(CFG_W - CNT_W){1'b0}}, count};

    // R7: both flow-control outputs are never active together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pause_req && backpressure));
endmodule

// File: tb/flow_pacer_tb.sv
module flow_pacer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        full_duplex = 1'b0;
    logic        fc_enable = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        pause_sent = 1'b0;
    logic        pause_req;
    logic [15:0] pause_time;
    logic        backpressure;
    logic [31:0] count_status;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    flow_pacer u_dut (
        .clk(clk), .rst(rst), .full_duplex(full_duplex), .fc_enable(fc_enable),
        .cfg_word(cfg_word), .pause_sent(pause_sent), .pause_req(pause_req),
        .pause_time(pause_time), .backpressure(backpressure),
        .count_status(count_status)
    );

    // {full_duplex, pause time [31:16], interval [15:0]}
    localparam logic [32:0] VEC [0:5] = '{
        {1'b1, 16'h0123, 16'd3},
        {1'b1, 16'hBEEF, 16'd7},
        {1'b1, 16'h0042, 16'd0},
        {1'b0, 16'd5,    16'd0},
        {1'b0, 16'd1,    16'd9},
        {1'b0, 16'd12,   16'd2}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(!pause_req && !backpressure, "R1 outputs", {pause_req, backpressure}, 0);
        chk(pause_time == 0, "R1 pause_time", pause_time, 0);
        chk(count_status == 0, "R1 status", count_status, 0);

        for (int v = 0; v < 6; v++) begin
            full_duplex = VEC[v][32];
            cfg_word    = VEC[v][31:0];
            step();
            fc_enable = 1'b1;
            if (VEC[v][32]) begin
                int gap;
                step();
                chk(pause_req, "R2 req", pause_req, 1);
                chk(pause_time == VEC[v][31:16], "R2 time", pause_time, VEC[v][31:16]);
                repeat (3) step();
                chk(pause_req, "R3 held", pause_req, 1);
                chk(count_status == 0, "R3 frozen", count_status, 0);
                pause_sent = 1'b1;
                step();
                pause_sent = 1'b0;
                chk(count_status == 0, "R4 cleared", count_status, 0);
                gap = 0;
                for (int c = 0; c < 30 && !pause_req; c++) begin
                    step();
                    gap++;
                end
                if (VEC[v][15:0] != 0) begin
                    chk(gap == VEC[v][15:0] + 1, "R4 gap", gap, VEC[v][15:0] + 1);
                    chk(count_status == VEC[v][15:0], "R4 count", count_status, VEC[v][15:0]);
                    pause_sent = 1'b1;
                    step();
                    pause_sent = 1'b0;
                    step();
                    chk(count_status == 1, "R4 restart", count_status, 1);
                end else begin
                    chk(!pause_req, "R5 no reissue", pause_req, 0);
                    chk(count_status == 0, "R5 count", count_status, 0);
                end
                fc_enable = 1'b0;
                step();
                chk(pause_req && pause_time == 0, "R6 zero frame", pause_time, 0);
                chk(count_status == 0, "R6 count", count_status, 0);
                pause_sent = 1'b1;
                step();
                pause_sent = 1'b0;
                chk(!pause_req, "R6 idle", pause_req, 0);
            end else begin
                int bp;
                int rq;
                bp = 0;
                rq = 0;
                for (int c = 0; c < VEC[v][31:16] + 6; c++) begin
                    step();
                    if (backpressure) bp++;
                    if (pause_req) rq++;
                end
                chk(bp == VEC[v][31:16], "R7 bp cycles", bp, VEC[v][31:16]);
                chk(count_status == VEC[v][31:16], "R7 count", count_status, VEC[v][31:16]);
                chk(rq == 0, "R7 no req", rq, 0);
                fc_enable = 1'b0;
                step();
                chk(!backpressure && count_status == 0, "R9 release", count_status, 0);
            end
            step();
        end

        // R8: zero length in half duplex
        full_duplex = 1'b0;
        cfg_word = 32'h0000_0004;
        fc_enable = 1'b1;
        begin
            int bp;
            bp = 0;
            for (int c = 0; c < 10; c++) begin
                step();
                if (backpressure) bp++;
            end
            chk(bp == 0, "R8 no bp", bp, 0);
        end
        fc_enable = 1'b0;
        step();

        // R9: early release mid-window
        cfg_word = {16'd50, 16'd0};
        fc_enable = 1'b1;
        repeat (6) step();
        chk(backpressure && count_status == 5, "R9 mid count", count_status, 5);
        fc_enable = 1'b0;
        step();
        chk(!backpressure, "R9 early bp", backpressure, 0);
        chk(count_status == 0, "R9 early count", count_status, 0);

        // R6: withdrawal while a request is still pending
        full_duplex = 1'b1;
        cfg_word = {16'h7777, 16'd4};
        fc_enable = 1'b1;
        step();
        step();
        fc_enable = 1'b0;
        step();
        chk(pause_req && pause_time == 0, "R6 pending withdraw", pause_time, 0);
        pause_sent = 1'b1;
        step();
        pause_sent = 1'b0;
        chk(!pause_req, "R6 idle after", pause_req, 0);
        chk(count_status[31:16] == 0, "R4 upper zero", count_status[31:16], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule